// File: doc/BRIEF.md
# Horizontal Pixel-Dropping Downscaler with Luma Smoothing

This block shrinks a video line horizontally by discarding pixels in a repeating pattern set by a small factor m. The pattern has two forms. In the sparse form one pixel of every m+1 is kept, and in the dense form only one pixel of every m+1 is discarded. Before a pixel is kept or discarded, its luma byte passes through a four-tap FIR filter. The filter weights the current pixel and the three pixels before it with user coefficients, so the surviving samples are smoothed. The chroma byte is not filtered and stays with its own pixel.

Pixels arrive as a valid-qualified stream. Each pixel carries a luma byte, a chroma byte and a flag that marks the first pixel of a line. Kept pixels leave on a registered valid-qualified output one cycle later. A 32-bit write port loads two words: a control word and a coefficient word. A write goes into a staging copy. The staging copy becomes active only when the next line starts, so every line is processed with a single set of settings.

Top module: `pds_downscaler`

## Requirements
- R1: After reset, out_valid is low and both staged words are zero. The block is therefore disabled and passes pixels through until new settings are written.
- R2: When cfg_sel is 0, a write loads the control word: bit 0 is enable, bits 4:1 are the factor m, and bit 6 selects the dense form. When cfg_sel is 1, a write loads the coefficient word: tap 4 is at bits 27:24, tap 3 at 19:16, tap 2 at 11:8 and tap 1 at 3:0. All other bits are ignored.
- R3: With enable at 0, every input pixel appears on the output exactly one cycle later with its luma unchanged.
- R4: In the sparse form (bit 6 = 0), pixel positions within a line are counted modulo m+1 from 0. Only the pixel at position 0 is kept.
- R5: In the dense form (bit 6 = 1), the pixel at position m of each group is dropped and all other pixels are kept.
- R6: With enable at 1, the output luma is (t4*p[n-3] + t3*p[n-2] + t2*p[n-1] + t1*p[n]) >> 4, where p[n] is the current pixel and t1..t4 are the four taps.
- R7: A pixel with in_sol set restarts the group count at position 0. It also fills every older filter tap with its own luma value.
- R8: If the shifted filter sum exceeds 255, the output luma is 255.
- R9: With m = 0, the sparse form keeps every pixel and the dense form drops every pixel.
- R10: The output chroma equals the chroma of the same input pixel, one cycle later.
- R11: New settings take effect at the first in_sol pixel accepted after the write cycle. A write made in the same cycle as an in_sol pixel applies to the line after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Word select: 0 control, 1 coefficients |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Input pixel valid |
| in_sol | input | 1 | First pixel of a line (used only with in_valid) |
| in_luma | input | 8 | Input luma |
| in_chroma | input | 8 | Input chroma |
| out_valid | output | 1 | Output pixel valid |
| out_luma | output | 8 | Output luma |
| out_chroma | output | 8 | Output chroma |

## Verification
The assertions relate each output to the input pixel accepted one cycle earlier and to the settings in force for that pixel. They assume the inputs are stable across each rising edge, and they ignore the first cycle after reset. The bench drives every input on the falling edge and samples on the next falling edge. Coefficient sets that do not sum to 16 are legal; the bench uses them on purpose to reach the saturation path.

// File: rtl/pds_pkg.sv
// Shared constants and types for the pixel-dropping downscaler.
// Assumes a 32-bit register word; the field positions below are fixed.
package pds_pkg;
    localparam int FACT_W      = 4;  // width of the drop factor m
    localparam int TAPS        = 4;  // luma filter length
    localparam int COEF_W      = 4;  // bits per filter coefficient
    localparam int COEF_STRIDE = 8;  // spacing of coefficients in the word
    localparam int EN_BIT      = 0;
    localparam int FACT_LSB    = 1;
    localparam int DENSE_BIT   = 6;

    // Settings that govern one line
    typedef struct packed {
        logic              dense;   // 1: keep m of m+1, 0: keep 1 of m+1
        logic [FACT_W-1:0] factor;  // m
        logic              enable;
    } pds_ctrl_t;
endpackage

// File: rtl/pds_cfg.sv
// Staging and active copies of the control and coefficient words.
// Writes land in the staging copy. A line start copies the staging copy
// into the active one, and the line-start pixel already uses the staged values.
// Assumes REG_W covers the highest coefficient field.
module pds_cfg
    import pds_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_sel,
    input  logic [REG_W-1:0]            wr_data,
    input  logic                        line_start,
    output pds_ctrl_t                   cfg_ctrl,
    output logic [TAPS-1:0][COEF_W-1:0] cfg_coef
);
    pds_ctrl_t                   stg_ctrl, act_ctrl, wr_ctrl;
    logic [TAPS-1:0][COEF_W-1:0] stg_coef, act_coef, wr_coef;
    logic                        unused_wr_bits;

    // Pull the control fields out of the write data
    always_comb begin
        wr_ctrl.enable = wr_data[EN_BIT];
        wr_ctrl.factor = wr_data[FACT_LSB +: FACT_W];
        wr_ctrl.dense  = wr_data[DENSE_BIT];
    end

    // Pull each coefficient out of its own byte lane
    for (genvar k = 0; k < TAPS; k++) begin : g_coef
        assign wr_coef[k] = wr_data[k*COEF_STRIDE +: COEF_W];
    end

    assign unused_wr_bits = ^wr_data;

    // Staging copy: written by the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_ctrl <= '0;
            stg_coef <= '0;
        end else if (wr_en) begin
            if (wr_sel) stg_coef <= wr_coef;
            else        stg_ctrl <= wr_ctrl;
        end
    end

    // Active copy: refreshed only at a line start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ctrl <= '0;
            act_coef <= '0;
        end else if (line_start) begin
            act_ctrl <= stg_ctrl;
            act_coef <= stg_coef;
        end
    end

    assign cfg_ctrl = line_start ? stg_ctrl : act_ctrl;
    assign cfg_coef = line_start ? stg_coef : act_coef;
endmodule

// File: rtl/pds_luma_fir.sv
// Four-tap luma FIR filter with saturation; the result is combinational.
// Tap index 0 weights the newest pixel. At a line start, every older tap
// takes the current pixel's value. History advances only on valid pixels.
module pds_luma_fir
    import pds_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pix_valid,
    input  logic                        pix_sol,
    input  logic [DATA_W-1:0]           pix_luma,
    input  logic [TAPS-1:0][COEF_W-1:0] coef,
    output logic [DATA_W-1:0]           filt_luma
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int SUM_W  = PROD_W + $clog2(TAPS);
    localparam int SHR_W  = SUM_W - COEF_W;

    logic [DATA_W-1:0] hist [TAPS-1];
    logic [DATA_W-1:0] win  [TAPS];
    logic [PROD_W-1:0] prod [TAPS];
    logic [SUM_W-1:0]  acc;
    logic [SHR_W-1:0]  shr;

    assign win[0] = pix_luma;
    for (genvar k = 1; k < TAPS; k++) begin : g_win
        assign win[k] = pix_sol ? pix_luma : hist[k-1];
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        assign prod[k] = PROD_W'(win[k]) * PROD_W'(coef[k]);
    end

    // Add up the weighted taps
    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) acc = acc + SUM_W'(prod[k]);
    end

    assign shr       = acc[SUM_W-1:COEF_W];
    assign filt_luma = (|shr[SHR_W-1:DATA_W]) ? '1 : shr[DATA_W-1:0];

    // Move the history along by one pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS-1; k++) hist[k] <= '0;
        end else if (pix_valid) begin
            hist[0] <= pix_luma;
            for (int k = 1; k < TAPS-1; k++) hist[k] <= win[k];
        end
    end
endmodule

// File: rtl/pds_decim.sv
// Keep/drop decision from a position counter modulo factor+1.
// Sparse form keeps position 0; dense form drops position factor.
// The counter restarts at a line start and advances on valid pixels only.
module pds_decim #(
    parameter int FACT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              pix_sol,
    input  logic [FACT_W-1:0] factor,
    input  logic              dense,
    output logic              keep
);
    logic [FACT_W-1:0] pos, cur;
    logic              at_end;

    assign cur    = pix_sol ? '0 : pos;
    assign at_end = (cur == factor);
    assign keep   = dense ? !at_end : (cur == '0);

    // Step through the group, wrapping after position factor
    always_ff @(posedge clk) begin
        if (!rst_n)         pos <= '0;
        else if (pix_valid) pos <= at_end ? '0 : cur + 1'b1;
    end
endmodule

// File: rtl/pds_downscaler.sv
// Top of the horizontal downscaler. It ties together the settings store,
// the luma filter and the drop decision, and registers kept pixels.
// Assumes in_sol matters only when in_valid is high. Latency is one cycle.
module pds_downscaler
    import pds_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic [DATA_W-1:0] in_luma,
    input  logic [DATA_W-1:0] in_chroma,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_luma,
    output logic [DATA_W-1:0] out_chroma
);
    pds_ctrl_t                   cfg_ctrl;
    logic [TAPS-1:0][COEF_W-1:0] cfg_coef;
    logic                        line_start, keep;
    logic [DATA_W-1:0]           filt_luma;

    assign line_start = in_valid & in_sol;

    pds_cfg #(.REG_W(REG_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr),
        .wr_sel     (cfg_sel),
        .wr_data    (cfg_wdata),
        .line_start (line_start),
        .cfg_ctrl   (cfg_ctrl),
        .cfg_coef   (cfg_coef)
    );

    pds_luma_fir #(.DATA_W(DATA_W)) u_fir (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (in_valid),
        .pix_sol   (in_sol),
        .pix_luma  (in_luma),
        .coef      (cfg_coef),
        .filt_luma (filt_luma)
    );

    pds_decim #(.FACT_W(FACT_W)) u_decim (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (in_valid),
        .pix_sol   (in_sol),
        .factor    (cfg_ctrl.factor),
        .dense     (cfg_ctrl.dense),
        .keep      (keep)
    );

    // Output register: valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid & (!cfg_ctrl.enable | keep);
    end

    // Output register: pixel data, updated on every accepted input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_luma   <= '0;
            out_chroma <= '0;
        end else if (in_valid) begin
            out_luma   <= cfg_ctrl.enable ? filt_luma : in_luma;
            out_chroma <= in_chroma;
        end
    end
endmodule

// File: rtl/pds_checker.sv
// Properties of the downscaler seen at its ports and its effective settings.
// Each check looks back one cycle and is skipped right after reset.
module pds_checker #(
    parameter int DATA_W = 8,
    parameter int FACT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_luma,
    input logic [DATA_W-1:0] in_chroma,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_luma,
    input logic [DATA_W-1:0] out_chroma,
    input logic              eff_en,
    input logic              eff_dense,
    input logic [FACT_W-1:0] eff_factor
);
    // R10: an output pixel follows an accepted input and keeps its chroma
    a_r10_chroma_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) && out_chroma == $past(in_chroma)));

    // R3: when disabled, every pixel passes with unchanged luma
    a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(eff_en))
        |-> (out_valid && out_luma == $past(in_luma)));

    // R9: dense form with m = 0 drops everything
    a_r9_dense_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && eff_en && eff_dense && eff_factor == '0))
        |-> !out_valid);

    // R9: sparse form with m = 0 keeps everything
    a_r9_sparse_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && eff_en && !eff_dense && eff_factor == '0))
        |-> out_valid);

    // R1: no output can appear without an input the cycle before
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid)) |-> !out_valid);
endmodule

bind pds_downscaler pds_checker #(.DATA_W(DATA_W), .FACT_W(pds_pkg::FACT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_luma    (in_luma),
    .in_chroma  (in_chroma),
    .out_valid  (out_valid),
    .out_luma   (out_luma),
    .out_chroma (out_chroma),
    .eff_en     (cfg_ctrl.enable),
    .eff_dense  (cfg_ctrl.dense),
    .eff_factor (cfg_ctrl.factor)
);

// File: tb/pds_downscaler_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared cycle by cycle against a reference model built from the requirements.
module pds_downscaler_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr, cfg_sel;
    logic [31:0] cfg_wdata;
    logic        in_valid, in_sol;
    logic [7:0]  in_luma, in_chroma;
    logic        out_valid;
    logic [7:0]  out_luma, out_chroma;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    kept     = 0;
    string tag      = "R1";

    // reference model state
    logic [31:0] m_stg_ctrl, m_stg_coef, m_act_ctrl, m_act_coef;
    int          h1, h2, h3, m_pos;
    bit          e_valid;
    int          e_luma, e_chroma;

    always #(CLK_PERIOD/2) clk = ~clk;

    pds_downscaler u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sol(in_sol),
        .in_luma(in_luma), .in_chroma(in_chroma), .out_valid(out_valid),
        .out_luma(out_luma), .out_chroma(out_chroma)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int tap(logic [31:0] w, int k);
        return int'(w[8*(k-1) +: 4]);
    endfunction

    // R6/R8 reference: weighted sum, shift, saturate
    function automatic int fir_ref(logic [31:0] cw, int p0, int p1, int p2, int p3);
        int s;
        s = (tap(cw,4)*p3 + tap(cw,3)*p2 + tap(cw,2)*p1 + tap(cw,1)*p0) >> 4;
        return (s > 255) ? 255 : s;
    endfunction

    // compare last cycle's result, then drive one new cycle and predict it
    task automatic step(bit v, bit s, int l, int c, bit we = 0, bit sel = 0,
                        logic [31:0] d = 32'h0);
        logic [31:0] ec, ek;
        int w1, w2, w3, cur, m;
        bit keep, en, dense;
        @(negedge clk);
        check(tag, "out_valid", int'(out_valid), int'(e_valid));
        if (e_valid) begin
            kept++;
            check(tag, "out_luma", int'(out_luma), e_luma);
            check("R10", "out_chroma", int'(out_chroma), e_chroma);
        end
        in_valid = v; in_sol = s; in_luma = l[7:0]; in_chroma = c[7:0];
        cfg_wr = we; cfg_sel = sel; cfg_wdata = d;
        e_valid = 1'b0;
        if (v) begin
            ec = s ? m_stg_ctrl : m_act_ctrl;
            ek = s ? m_stg_coef : m_act_coef;
            if (s) begin m_act_ctrl = ec; m_act_coef = ek; end
            en = ec[0]; m = int'(ec[4:1]); dense = ec[6];
            w1 = s ? l : h1; w2 = s ? l : h2; w3 = s ? l : h3;
            cur  = s ? 0 : m_pos;
            keep = dense ? (cur != m) : (cur == 0);
            m_pos = (cur == m) ? 0 : cur + 1;
            h3 = w2; h2 = w1; h1 = l;
            e_valid  = !en || keep;
            e_luma   = en ? fir_ref(ek, l, w1, w2, w3) : l;
            e_chroma = c;
        end
        if (we) begin
            if (sel) m_stg_coef = d & 32'h0F0F0F0F;
            else     m_stg_ctrl = d & 32'h0000005F;
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0);
    endtask

    function automatic logic [31:0] ctrl_w(bit en, int m, bit dense);
        return {25'd0, dense, 1'b0, 4'(m), en};
    endfunction

    function automatic logic [31:0] coef_w(int t4, int t3, int t2, int t1);
        return {4'd0, 4'(t4), 4'd0, 4'(t3), 4'd0, 4'(t2), 4'd0, 4'(t1)};
    endfunction

    // one line of n pixels with a simple luma ramp
    task automatic line(int n, int base);
        for (int i = 0; i < n; i++) step(1, i == 0, (base + 17*i) & 255, (i*7 + 3) & 255);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_stg_ctrl = 0; m_stg_coef = 0; m_act_ctrl = 0; m_act_coef = 0;
        h1 = 0; h2 = 0; h3 = 0; m_pos = 0; e_valid = 0; e_luma = 0; e_chroma = 0;
        rst_n = 0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = 0;
        in_valid = 0; in_sol = 0; in_luma = 0; in_chroma = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state, zero settings mean pass-through
        tag = "R1"; idle();
        line(6, 40);

        // R3: disabled pass-through with random pixels and gaps
        tag = "R3";
        for (int i = 0; i < 40; i++)
            step($urandom_range(0,3) != 0, i == 0, $urandom_range(0,255), $urandom_range(0,255));

        // R11: writes without a line start leave the current line untouched
        tag = "R11";
        step(0, 0, 0, 0, 1, 1, coef_w(4, 4, 4, 4));
        step(0, 0, 0, 0, 1, 0, ctrl_w(1, 2, 0));
        for (int i = 0; i < 6; i++) step(1, 0, 9*i, i);
        // R11: a write in the same cycle as a line start waits for the next line
        step(1, 1, 100, 1, 1, 0, ctrl_w(1, 0, 1));
        for (int i = 1; i < 6; i++) step(1, 0, 20*i, i);

        // R4: sparse form, m = 2, 12 pixels keep 4
        tag = "R4"; step(0, 0, 0, 0, 1, 0, ctrl_w(1, 2, 0));
        idle(); kept = 0;
        line(12, 5); idle(); idle();
        check("R4", "kept count", kept, 4);

        // R5: dense form, m = 3, 12 pixels keep 9
        tag = "R5"; step(0, 0, 0, 0, 1, 0, ctrl_w(1, 3, 1));
        idle(); kept = 0;
        line(12, 9); idle(); idle();
        check("R5", "kept count", kept, 9);

        // R2/R6: uneven taps place each weight at its own pixel age; reserved bits set
        tag = "R6";
        step(0, 0, 0, 0, 1, 1, coef_w(8, 4, 2, 2) | 32'hF0F0F0F0);
        step(0, 0, 0, 0, 1, 0, ctrl_w(1, 0, 0) | 32'hFFFFFF20);
        tag = "R2"; line(10, 0);

        // R7: line start refills history; step luma shows the fill
        tag = "R7";
        step(1, 1, 200, 1); step(1, 0, 0, 2); step(1, 0, 0, 3); step(1, 0, 0, 4);
        step(1, 1, 16, 5); step(1, 0, 240, 6); step(1, 0, 240, 7);

        // R8: taps summing to 60 with bright pixels saturate
        tag = "R8"; step(0, 0, 0, 0, 1, 1, coef_w(15, 15, 15, 15));
        line(5, 200);
        step(1, 1, 255, 0); step(1, 0, 255, 1);

        // R9: m = 0 in both forms
        tag = "R9"; step(0, 0, 0, 0, 1, 0, ctrl_w(1, 0, 1));
        idle(); kept = 0; line(8, 3); idle(); idle();
        check("R9", "dense m=0 kept", kept, 0);
        step(0, 0, 0, 0, 1, 0, ctrl_w(1, 0, 0));
        idle(); kept = 0; line(8, 3); idle(); idle();
        check("R9", "sparse m=0 kept", kept, 8);

        // random traffic: random settings written at random times
        tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            bit we;
            we = ($urandom_range(0, 40) == 0);
            step($urandom_range(0, 4) != 0, $urandom_range(0, 24) == 0,
                 $urandom_range(0, 255), $urandom_range(0, 255),
                 we, $urandom_range(0, 1) == 1, $urandom());
        end
        idle(); idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule